// File: doc/BRIEF.md
# Mailbox Command Register Interface

This block is the device-side end of a byte-wide mailbox. A host places a 16-bit argument and an 8-bit command code into four outgoing mailbox bytes. Writing the command byte launches the command. The block sends it through a fixed-latency execution pipeline, applies it to a small register file, and then posts a 16-bit result and an echo of the command code into four incoming mailbox bytes. The register file holds the digital output latch, the divisors and pulse counts of two PWM channels, and the PWM enable mask. The last incoming byte always shows the live digital input pins.

No busy flag exists. The host learns that a command has finished by polling the echo byte until it holds the code it sent. Because a repeated command would leave the echo unchanged, command 0x00 clears the echo between two identical commands. A status command reads back the value last written with any storing command code.

Top module: `mbox_cmd_if`

## Requirements
- R1: After reset, incoming bytes 0x1C, 0x1D and 0x1E read zero, and the output latch and all PWM registers are zero.
- R2: Outgoing bytes at 0x0C–0x0F are writable and read back what was written. 0x0C is the argument low byte and 0x0D the argument high byte. A write to 0x0E supplies the command code and launches the command.
- R3: Reading 0x1F returns the current value of the 8-bit digital input pins.
- R4: A command written on clock edge k completes on edge k+EXEC_LAT. The result low and high bytes (0x1C, 0x1D) and the echo byte (0x1E) all change on that edge, and on no other edge.
- R5: Code 0x01 loads the argument's low byte into the output latch and returns that byte. Code 0x02 returns the latch, zero-extended.
- R6: Codes 0x10 and 0x11 set the high and low divisors of PWM channel 0, and codes 0x12 and 0x13 set those of channel 1. Codes 0x14 and 0x15 set the pulse counts of channels 0 and 1. Each of these returns its argument. Code 0x1F loads the enable mask from argument bits [1:0] (bit n = channel n) and returns the masked value.
- R7: Code 0x03 takes a command code in its argument's low byte. It returns the value last stored by that code: the zero-extended latch for 0x01, the mask for 0x1F, the register for 0x10–0x15, and zero for any other code.
- R8: Code 0x00 returns zero and echoes 0x00. This makes a later repeat of a command visible as a change in the echo byte.
- R9: Any other code echoes itself, returns zero and changes no register.
- R10: Writes to 0x0C, 0x0D and 0x0F launch nothing. Addresses outside the two mailbox windows read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address of the register bus |
| wr_en_i | input | 1 | Write strobe for one cycle |
| wr_data_i | input | 8 | Write data byte |
| rd_data_o | output | 8 | Read data byte for addr_i (combinational) |
| din_i | input | 8 | Live digital inputs |
| dout_o | output | 8 | Digital output latch |
| pwm_en_o | output | 2 | PWM channel enable mask |
| pwm_hi_div_o | output | 32 | High divisors, channel n at [16n+15:16n] |
| pwm_lo_div_o | output | 32 | Low divisors, channel n at [16n+15:16n] |
| pwm_cnt_o | output | 32 | Pulse counts, channel n at [16n+15:16n] |

## Verification
Commands are issued with distinct argument patterns: asymmetric bytes such as 0x00C3 and 0xBEEF, all-ones, and a different value for each PWM register. A swapped byte lane, a misrouted channel or a wrong register therefore produces a visibly wrong result. The mailbox is read on every cycle between launch and completion, so an echo or result that lands one cycle early or late, or on different edges, is caught. The same command is repeated with a clear command in between, and again without one, which separates a correct echo update from a stale one. Unknown codes, status reads of never-written codes, and writes to the non-launching bytes show that nothing changes where nothing should.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int NUM_PWM = 2;
  localparam int ARG_W   = 16;
  localparam int OB_BASE = 'h0C;
  localparam int IB_BASE = 'h1C;

  localparam logic [7:0] CMD_CLR     = 8'h00;
  localparam logic [7:0] CMD_SET_OUT = 8'h01;
  localparam logic [7:0] CMD_GET_OUT = 8'h02;
  localparam logic [7:0] CMD_STATUS  = 8'h03;
  localparam logic [7:0] CMD_PWM_ENA = 8'h1F;

  typedef struct packed {
    logic             vld;
    logic [7:0]       code;
    logic [ARG_W-1:0] arg;
  } mbox_req_t;

  function automatic logic [7:0] hi_code(int ch);
    return 8'(8'h10 + 2 * ch);
  endfunction
  function automatic logic [7:0] lo_code(int ch);
    return 8'(8'h11 + 2 * ch);
  endfunction
  function automatic logic [7:0] cnt_code(int ch);
    return 8'(8'h14 + ch);
  endfunction
endpackage

// File: rtl/mbox_host_regs.sv
module mbox_host_regs
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  wr_en_i,
  input  logic [7:0]            wr_data_i,
  input  logic [ARG_W-1:0]      res_i,
  input  logic [7:0]            echo_i,
  input  logic [7:0]            din_i,
  output logic [7:0]            rd_data_o,
  output mbox_req_t             req_o
);
  localparam logic [ADDR_W-3:0] OB_PAGE = (ADDR_W-2)'(OB_BASE >> 2);
  localparam logic [ADDR_W-3:0] IB_PAGE = (ADDR_W-2)'(IB_BASE >> 2);

  logic [7:0] ob_q [4];
  logic       ob_hit, ib_hit;

  assign ob_hit = addr_i[ADDR_W-1:2] == OB_PAGE;
  assign ib_hit = addr_i[ADDR_W-1:2] == IB_PAGE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 4; i++) ob_q[i] <= '0;
    end else if (wr_en_i && ob_hit) begin
      ob_q[addr_i[1:0]] <= wr_data_i;
    end
  end

  // launch on the command byte; argument comes from bytes already held
  always_comb begin
    req_o.vld  = wr_en_i && ob_hit && (addr_i[1:0] == 2'd2);
    req_o.code = wr_data_i;
    req_o.arg  = {ob_q[1], ob_q[0]};
  end

  always_comb begin
    rd_data_o = '0;
    if (ob_hit) rd_data_o = ob_q[addr_i[1:0]];
    else if (ib_hit) begin
      case (addr_i[1:0])
        2'd0: rd_data_o = res_i[7:0];
        2'd1: rd_data_o = res_i[15:8];
        2'd2: rd_data_o = echo_i;
        default: rd_data_o = din_i;
      endcase
    end
  end

  assert_no_launch_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i[1:0] != 2'd2) |-> !req_o.vld);
endmodule

// File: rtl/mbox_delay.sv
module mbox_delay
  import mbox_pkg::*;
#(
  parameter int LAT = 3
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  mbox_req_t req_i,
  output mbox_req_t req_o
);
  mbox_req_t stg_q [LAT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LAT; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= req_i;
      for (int i = 1; i < LAT; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign req_o = stg_q[LAT-1];
endmodule

// File: rtl/mbox_exec.sv
module mbox_exec
  import mbox_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  mbox_req_t                req_i,
  output logic [ARG_W-1:0]         res_o,
  output logic [7:0]               echo_o,
  output logic [7:0]               dout_o,
  output logic [NUM_PWM-1:0]       pwm_en_o,
  output logic [NUM_PWM*ARG_W-1:0] pwm_hi_div_o,
  output logic [NUM_PWM*ARG_W-1:0] pwm_lo_div_o,
  output logic [NUM_PWM*ARG_W-1:0] pwm_cnt_o
);
  logic [ARG_W-1:0]   res_q, res_nxt, stat_val;
  logic [7:0]         echo_q, do_q, sel;
  logic [NUM_PWM-1:0] en_q;
  logic [ARG_W-1:0]   hi_q [NUM_PWM];
  logic [ARG_W-1:0]   lo_q [NUM_PWM];
  logic [ARG_W-1:0]   cnt_q [NUM_PWM];

  always_comb begin
    sel      = req_i.arg[7:0];
    stat_val = '0;
    if (sel == CMD_SET_OUT) stat_val = {8'h00, do_q};
    if (sel == CMD_PWM_ENA) stat_val = {{(ARG_W-NUM_PWM){1'b0}}, en_q};
    for (int ch = 0; ch < NUM_PWM; ch++) begin
      if (sel == hi_code(ch))  stat_val = hi_q[ch];
      if (sel == lo_code(ch))  stat_val = lo_q[ch];
      if (sel == cnt_code(ch)) stat_val = cnt_q[ch];
    end
    res_nxt = '0;
    case (req_i.code)
      CMD_SET_OUT: res_nxt = {8'h00, req_i.arg[7:0]};
      CMD_GET_OUT: res_nxt = {8'h00, do_q};
      CMD_STATUS:  res_nxt = stat_val;
      CMD_PWM_ENA: res_nxt = {{(ARG_W-NUM_PWM){1'b0}}, req_i.arg[NUM_PWM-1:0]};
      default: begin
        for (int ch = 0; ch < NUM_PWM; ch++)
          if (req_i.code == hi_code(ch) || req_i.code == lo_code(ch) ||
              req_i.code == cnt_code(ch))
            res_nxt = req_i.arg;
      end
    endcase
  end

  // result, echo and register update all land on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q  <= '0;
      echo_q <= '0;
      do_q   <= '0;
      en_q   <= '0;
      for (int ch = 0; ch < NUM_PWM; ch++) begin
        hi_q[ch]  <= '0;
        lo_q[ch]  <= '0;
        cnt_q[ch] <= '0;
      end
    end else if (req_i.vld) begin
      res_q  <= res_nxt;
      echo_q <= req_i.code;
      if (req_i.code == CMD_SET_OUT) do_q <= req_i.arg[7:0];
      if (req_i.code == CMD_PWM_ENA) en_q <= req_i.arg[NUM_PWM-1:0];
      for (int ch = 0; ch < NUM_PWM; ch++) begin
        if (req_i.code == hi_code(ch))  hi_q[ch]  <= req_i.arg;
        if (req_i.code == lo_code(ch))  lo_q[ch]  <= req_i.arg;
        if (req_i.code == cnt_code(ch)) cnt_q[ch] <= req_i.arg;
      end
    end
  end

  for (genvar ch = 0; ch < NUM_PWM; ch++) begin : g_pwm
    assign pwm_hi_div_o[ch*ARG_W +: ARG_W] = hi_q[ch];
    assign pwm_lo_div_o[ch*ARG_W +: ARG_W] = lo_q[ch];
    assign pwm_cnt_o[ch*ARG_W +: ARG_W]    = cnt_q[ch];
  end

  assign res_o    = res_q;
  assign echo_o   = echo_q;
  assign dout_o   = do_q;
  assign pwm_en_o = en_q;

  assert_mailbox_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i.vld |=> ($stable(res_q) && $stable(echo_q)));
  assert_latch_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i.vld && req_i.code == CMD_SET_OUT) |=> $stable(do_q));
  assert_mask_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i.vld && req_i.code == CMD_PWM_ENA) |=> $stable(en_q));
  assert_clear_echo_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i.vld && req_i.code == CMD_CLR) |=> (echo_q == 8'h00 && res_q == '0));
endmodule

// File: rtl/mbox_cmd_if.sv
module mbox_cmd_if
  import mbox_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int EXEC_LAT = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     wr_en_i,
  input  logic [7:0]               wr_data_i,
  output logic [7:0]               rd_data_o,
  input  logic [7:0]               din_i,
  output logic [7:0]               dout_o,
  output logic [NUM_PWM-1:0]       pwm_en_o,
  output logic [NUM_PWM*ARG_W-1:0] pwm_hi_div_o,
  output logic [NUM_PWM*ARG_W-1:0] pwm_lo_div_o,
  output logic [NUM_PWM*ARG_W-1:0] pwm_cnt_o
);
  mbox_req_t        launch, done;
  logic [ARG_W-1:0] res;
  logic [7:0]       echo;

  mbox_host_regs #(.ADDR_W(ADDR_W)) u_host (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .res_i(res), .echo_i(echo), .din_i(din_i),
    .rd_data_o(rd_data_o), .req_o(launch)
  );

  mbox_delay #(.LAT(EXEC_LAT)) u_delay (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(launch), .req_o(done)
  );

  mbox_exec u_exec (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(done), .res_o(res), .echo_o(echo),
    .dout_o(dout_o), .pwm_en_o(pwm_en_o), .pwm_hi_div_o(pwm_hi_div_o),
    .pwm_lo_div_o(pwm_lo_div_o), .pwm_cnt_o(pwm_cnt_o)
  );
endmodule

// File: tb/sim_mbox_cmd_if.sv
`timescale 1ns/1ps
module sim_mbox_cmd_if;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic [1:0]  pwm_en;
  logic [31:0] pwm_hi, pwm_lo, pwm_cnt;

  always #4 clk = ~clk;

  mbox_cmd_if #(.ADDR_W(6), .EXEC_LAT(LAT)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .din_i(din), .dout_o(dout),
    .pwm_en_o(pwm_en), .pwm_hi_div_o(pwm_hi), .pwm_lo_div_o(pwm_lo),
    .pwm_cnt_o(pwm_cnt)
  );

  int errors = 0, checks = 0, cyc = 0;
  bit finished = 0;

  // reference model
  int m_ob[4];
  int m_res = 0, m_echo = 0, m_do = 0, m_en = 0;
  int m_hi[2], m_lo[2], m_cnt[2];
  int q_code[$], q_arg[$], q_due[$];

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int stat_of(int c);
    if (c == 'h01) return m_do;
    if (c == 'h1F) return m_en;
    if (c >= 'h10 && c <= 'h13) return ((c & 1) != 0) ? m_lo[(c - 'h10) / 2] : m_hi[(c - 'h10) / 2];
    if (c == 'h14 || c == 'h15) return m_cnt[c - 'h14];
    return 0;
  endfunction

  task automatic apply(int c, int a);
    int r = 0;
    case (c)
      'h01: begin m_do = a & 'hFF; r = m_do; end
      'h02: r = m_do;
      'h03: r = stat_of(a & 'hFF);
      'h10, 'h12: begin m_hi[(c - 'h10) / 2] = a; r = a; end
      'h11, 'h13: begin m_lo[(c - 'h10) / 2] = a; r = a; end
      'h14, 'h15: begin m_cnt[c - 'h14] = a; r = a; end
      'h1F: begin m_en = a & 3; r = m_en; end
      default: r = 0;
    endcase
    m_res = r;
    m_echo = c;
  endtask

  function automatic int model_read(int a);
    if (a >= 'h0C && a <= 'h0F) return m_ob[a - 'h0C];
    case (a)
      'h1C: return m_res & 'hFF;
      'h1D: return (m_res >> 8) & 'hFF;
      'h1E: return m_echo;
      'h1F: return din;
      default: return 0;
    endcase
  endfunction

  // one bus cycle; outputs compared every clock against the model
  task automatic step(bit wr, int a, int d, string tag);
    @(negedge clk);
    check("R5 dout", dout, m_do);
    check("R6 pwm_en", pwm_en, m_en);
    for (int ch = 0; ch < 2; ch++) begin
      check("R6 hi_div", pwm_hi[ch*16 +: 16], m_hi[ch]);
      check("R6 lo_div", pwm_lo[ch*16 +: 16], m_lo[ch]);
      check("R6 count", pwm_cnt[ch*16 +: 16], m_cnt[ch]);
    end
    wr_en = wr; addr = 6'(a); wr_data = 8'(d);
    #1;
    if (!wr) check(tag, rd_data, model_read(a));
    @(posedge clk);
    if (wr && a >= 'h0C && a <= 'h0F) begin
      if (a == 'h0E) begin
        q_code.push_back(d); q_arg.push_back(m_ob[0] | (m_ob[1] << 8));
        q_due.push_back(cyc + 1 + LAT);
      end
      m_ob[a - 'h0C] = d;
    end
    cyc++;
    while (q_due.size() > 0 && q_due[0] == cyc) begin
      apply(q_code.pop_front(), q_arg.pop_front());
      void'(q_due.pop_front());
    end
  endtask

  task automatic issue(int c, int a, string tag);
    step(1, 'h0C, a & 'hFF, tag);
    step(1, 'h0D, (a >> 8) & 'hFF, tag);
    step(1, 'h0E, c, tag);
    step(1, 'h0F, 0, tag);
    for (int i = 0; i < 2; i++) begin
      step(0, 'h1E, 0, tag);
      step(0, 'h1C, 0, tag);
      step(0, 'h1D, 0, tag);
    end
  endtask

  initial begin
    for (int i = 0; i < 4; i++) m_ob[i] = 0;
    for (int i = 0; i < 2; i++) begin m_hi[i] = 0; m_lo[i] = 0; m_cnt[i] = 0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    step(0, 'h1C, 0, "R1"); step(0, 'h1D, 0, "R1"); step(0, 'h1E, 0, "R1");
    // R3 live inputs
    din = 8'hA5; step(0, 'h1F, 0, "R3");
    din = 8'h3C; step(0, 'h1F, 0, "R3");
    // R2 outgoing readback, R10 non-launching writes
    step(1, 'h0C, 'h34, "R2"); step(1, 'h0D, 'h12, "R2"); step(1, 'h0F, 'h5A, "R2");
    step(0, 'h0C, 0, "R2"); step(0, 'h0D, 0, "R2"); step(0, 'h0F, 0, "R2");
    for (int i = 0; i < 4; i++) step(0, 'h1E, 0, "R10");
    step(0, 'h00, 0, "R10"); step(0, 'h20, 0, "R10"); step(0, 'h3F, 0, "R10");
    // R4, R5 output latch
    issue('h01, 'h00C3, "R4");
    issue('h02, 'hFF00, "R5");
    // R6 PWM registers and mask
    issue('h10, 'h1111, "R6"); issue('h11, 'h2222, "R6");
    issue('h12, 'h3333, "R6"); issue('h13, 'h4444, "R6");
    issue('h14, 'h5A5A, "R6"); issue('h15, 'hA5A5, "R6");
    issue('h1F, 'hFFFF, "R6");
    // R7 status readback
    issue('h03, 'h0012, "R7"); issue('h03, 'h0015, "R7");
    issue('h03, 'h001F, "R7"); issue('h03, 'h0001, "R7");
    issue('h03, 'h0040, "R7");
    // R8 clear then repeat
    issue('h02, 0, "R8"); issue('h00, 'h1234, "R8"); issue('h02, 0, "R8");
    issue('h02, 0, "R8");
    // R9 unknown code
    issue('h77, 'hBEEF, "R9");
    issue('h1F, 'h0001, "R6");
    issue('h5C, 'h0000, "R9");
    // back-to-back launches
    step(1, 'h0E, 'h02, "R4"); step(1, 'h0E, 'h03, "R4"); step(1, 'h0E, 'h00, "R4");
    for (int i = 0; i < 6; i++) step(0, 'h1E, 0, "R4");
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule